// File: doc/BRIEF.md
# Multicycle Five-Instruction RISC Core

This block is a small non-pipelined processor core. Every instruction walks through a fixed series of steps driven by one state machine: FETCH, DECODE, EXEC, MEM and, for instructions that produce a register result, WB. The steps pass values through named holding registers. These are the instruction register, the next-PC register, two operand registers, the sign-extended immediate register, the ALU result register and the load-data register. The core has a 32-entry by 32-bit register file. One memory port carries both instruction fetches and data accesses. The port reads combinationally: read data belongs to the address shown in the same cycle. Writes are taken at the clock edge while the write enable is high.

The instruction set has five instructions: register add, add-immediate, load word, store word and branch-if-equal. The branch compares its operands in EXEC and places 1 or 0 in the result register. The MEM step reads that result to choose between the sequential next PC and the branch target. Any other opcode behaves as a no-op that only advances the PC.

Top module: `mcp_core`

State transitions: FETCH -> DECODE -> EXEC -> MEM always. MEM -> WB for add, add-immediate and load. MEM -> FETCH for store, branch and no-op. WB -> FETCH always.

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and the state machine to FETCH. While reset is held, the write enable stays low and the address is 0.
- R2: In FETCH the address port shows the PC, the instruction register loads the word read, and the next-PC register loads PC+4. Opcode is bits 31:26, first source is 25:21, second source/target is 20:16, destination is 15:11, function is 5:0, and the immediate is 15:0.
- R3: Opcode 0x00 with function 0x20 writes the sum of the two source registers into the register named by bits 15:11.
- R4: Opcode 0x08 writes the first source plus the sign-extended 16-bit immediate into the register named by bits 20:16.
- R5: Opcode 0x23 (load) and opcode 0x2B (store) use byte address = first source + sign-extended immediate. A load writes the word read into register bits 20:16. A store writes that register's value, with the write enable high only in the MEM step.
- R6: Opcode 0x04 branches when the two source registers are equal. The new PC is PC+4 plus the immediate shifted left by two. Otherwise the PC becomes PC+4.
- R7: Register 0 reads as zero, and writes to it have no effect.
- R8: Add, add-immediate and load take 5 cycles, while store, branch and no-op take 4. The PC changes only at the end of MEM, so a store that starts in cycle n writes in cycle n+3.
- R9: An unrecognised opcode, or opcode 0 with another function code, writes neither memory nor a register and advances the PC by 4.
- R10: All 31 writable registers hold independent values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address for fetch or data access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data for the current address (combinational) |
| mem_we | output | 1 | Write strobe, one cycle in MEM of a store |

## Verification
The bench builds the core with its default 32-bit word and 32 registers, attached to a 256-word behavioural memory. This small setup makes a near-exhaustive register sweep possible: every writable register receives a distinct signed immediate and is then stored back, so the expected values are simple arithmetic in the bench.

The same program also exercises the other cases:
- a negative immediate and an immediate at the positive limit;
- a load/store round trip;
- a taken and a not-taken branch;
- an attempted write to register 0;
- an unknown opcode.

The cycle numbers of the first two store strobes are computed from the step counts and checked exactly.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] FN_ADD    = 6'h20;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEM,
        ST_WB
    } step_t;

    typedef enum logic [2:0] {
        K_ADD,
        K_ADDI,
        K_LW,
        K_SW,
        K_BEQ,
        K_NOP
    } kind_t;

    typedef struct packed {
        logic ir_ld;
        logic ab_ld;
        logic y_ld;
        logic alu_imm;
        logic alu_eq;
        logic pc_ld;
        logic pc_br;
        logic m_ld;
        logic mem_we;
        logic addr_y;
        logic rf_we;
        logic rf_rd;
        logic rf_m;
    } ctl_t;

endpackage

// File: rtl/mcp_regfile.sv
module mcp_regfile #(
    parameter int XLEN    = 32,
    parameter int REG_CNT = 32,
    localparam int RA_W   = $clog2(REG_CNT)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RA_W-1:0] ra1,
    input  logic [RA_W-1:0] ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    input  logic            we,
    input  logic [RA_W-1:0] wa,
    input  logic [XLEN-1:0] wd
);

    logic [XLEN-1:0] regs [REG_CNT];

    // entry 0 is never written; the read side also forces it to zero
    always_ff @(posedge clk) begin
        if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

    // R10: a write to a non-zero entry is readable on port 1 in the next cycle
    p_write_lands_r10: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0 && ra1 == wa && $stable(ra1)) |=> rd1 == $past(wd));

endmodule

// File: rtl/mcp_alu.sv
module mcp_alu #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [XLEN-1:0] imm,
    input  logic            use_imm,
    input  logic            do_eq,
    output logic [XLEN-1:0] res
);

    logic [XLEN-1:0] second;

    always_comb begin
        second = use_imm ? imm : opb;
        if (do_eq) begin
            res = {{(XLEN-1){1'b0}}, (opa == opb)};
        end else begin
            res = opa + second;
        end
    end

endmodule

// File: rtl/mcp_ctrl.sv
module mcp_ctrl
    import mcp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output step_t      step,
    output ctl_t       ctl
);

    kind_t kind;
    step_t step_nx;

    always_comb begin
        unique case (opcode)
            OPC_RTYPE: kind = (funct == FN_ADD) ? K_ADD : K_NOP;
            OPC_ADDI:  kind = K_ADDI;
            OPC_LW:    kind = K_LW;
            OPC_SW:    kind = K_SW;
            OPC_BEQ:   kind = K_BEQ;
            default:   kind = K_NOP;
        endcase
    end

    always_comb begin
        unique case (step)
            ST_FETCH:  step_nx = ST_DECODE;
            ST_DECODE: step_nx = ST_EXEC;
            ST_EXEC:   step_nx = ST_MEM;
            ST_MEM:    step_nx = (kind == K_ADD || kind == K_ADDI || kind == K_LW)
                                 ? ST_WB : ST_FETCH;
            ST_WB:     step_nx = ST_FETCH;
            default:   step_nx = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= ST_FETCH;
        end else begin
            step <= step_nx;
        end
    end

    always_comb begin
        ctl = '0;
        unique case (step)
            ST_FETCH: begin
                ctl.ir_ld = 1'b1;
            end
            ST_DECODE: begin
                ctl.ab_ld = 1'b1;
            end
            ST_EXEC: begin
                ctl.y_ld    = 1'b1;
                ctl.alu_imm = (kind == K_ADDI) || (kind == K_LW) || (kind == K_SW);
                ctl.alu_eq  = (kind == K_BEQ);
            end
            ST_MEM: begin
                ctl.pc_ld  = 1'b1;
                ctl.pc_br  = (kind == K_BEQ);
                ctl.m_ld   = (kind == K_LW);
                ctl.mem_we = (kind == K_SW);
                ctl.addr_y = (kind == K_LW) || (kind == K_SW);
            end
            ST_WB: begin
                ctl.rf_we = 1'b1;
                ctl.rf_rd = (kind == K_ADD);
                ctl.rf_m  = (kind == K_LW);
            end
            default: ctl = '0;
        endcase
    end

    // R8: every fetch is followed by decode
    p_fetch_to_decode_r8: assert property (@(posedge clk) disable iff (rst)
        (step == ST_FETCH) |=> (step == ST_DECODE));

    // R8: write-back only follows the memory step
    p_wb_after_mem_r8: assert property (@(posedge clk) disable iff (rst)
        (step == ST_WB) |-> ($past(step) == ST_MEM));

endmodule

// File: rtl/mcp_core.sv
module mcp_core
    import mcp_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int REG_CNT = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            mem_we
);

    localparam int RA_W   = $clog2(REG_CNT);
    localparam int IMM_W  = 16;
    localparam int SRC1_LO = 21;
    localparam int SRC2_LO = 16;
    localparam int DST_LO  = 11;

    step_t step;
    ctl_t  ctl;

    logic [XLEN-1:0] pc, ir, npc, opa, opb, imm, y, m;
    logic [XLEN-1:0] rd1, rd2, alu_res, br_target, imm_sx, wd;
    logic [RA_W-1:0] wa;

    mcp_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .opcode (ir[31:26]),
        .funct  (ir[5:0]),
        .step   (step),
        .ctl    (ctl)
    );

    mcp_regfile #(.XLEN(XLEN), .REG_CNT(REG_CNT)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (ir[SRC1_LO +: RA_W]),
        .ra2 (ir[SRC2_LO +: RA_W]),
        .rd1 (rd1),
        .rd2 (rd2),
        .we  (ctl.rf_we),
        .wa  (wa),
        .wd  (wd)
    );

    mcp_alu #(.XLEN(XLEN)) u_alu (
        .opa     (opa),
        .opb     (opb),
        .imm     (imm),
        .use_imm (ctl.alu_imm),
        .do_eq   (ctl.alu_eq),
        .res     (alu_res)
    );

    assign imm_sx    = {{(XLEN-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
    assign br_target = npc + (imm << 2);
    assign wa        = ctl.rf_rd ? ir[DST_LO +: RA_W] : ir[SRC2_LO +: RA_W];
    assign wd        = ctl.rf_m ? m : y;

    assign mem_addr  = ctl.addr_y ? y : pc;
    assign mem_wdata = opb;
    assign mem_we    = ctl.mem_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            ir  <= '0;
            npc <= '0;
            opa <= '0;
            opb <= '0;
            imm <= '0;
            y   <= '0;
            m   <= '0;
        end else begin
            if (ctl.ir_ld) begin
                ir  <= mem_rdata;
                npc <= pc + XLEN'(4);
            end
            if (ctl.ab_ld) begin
                opa <= rd1;
                opb <= rd2;
                imm <= imm_sx;
            end
            if (ctl.y_ld) begin
                y <= alu_res;
            end
            if (ctl.m_ld) begin
                m <= mem_rdata;
            end
            if (ctl.pc_ld) begin
                pc <= (ctl.pc_br && y == XLEN'(1)) ? br_target : npc;
            end
        end
    end

    // R2: instruction fetch addresses the PC and never writes
    p_fetch_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (step == ST_FETCH) |-> (mem_addr == pc && !mem_we));

    // R8: the PC only moves at the end of the memory step
    p_pc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (step != ST_MEM) |=> $stable(pc));

    // R6: an unequal branch falls through to the sequential address
    p_beq_fallthru_r6: assert property (@(posedge clk) disable iff (rst)
        (step == ST_MEM && ir[31:26] == OPC_BEQ && y == '0) |=> (pc == $past(npc)));

    // R5: a store strobe carries the computed address
    p_store_addr_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (step == ST_MEM && mem_addr == y));

endmodule

// File: tb/sim_mcp_core.sv
`timescale 1ns/1ps
module sim_mcp_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;

    logic [31:0] mem [256];
    int          cyc = 0;
    int          nchk = 0;
    int          nerr = 0;
    int          nwr = 0;
    int          wcyc0 = -1;
    int          wcyc1 = -1;

    localparam int HALT_IDX = 80;

    always #2.5 clk = ~clk;

    mcp_core u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we)
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        cyc <= rst ? 0 : cyc + 1;
    end

    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (nwr == 0) wcyc0 = cyc;
            if (nwr == 1) wcyc1 = cyc;
            nwr = nwr + 1;
        end
    end

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic int sweep_val(input int k);
        return k * 1237 - 20000;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (!ok) begin
            nerr = nerr + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc != n) @(negedge clk);
    endtask

    initial begin
        int p;
        int guard;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        mem[0]  = enc_i(6'h08, 0, 1, 5);          // r1 = 5
        mem[1]  = enc_i(6'h08, 0, 2, -3);         // r2 = -3
        mem[2]  = enc_r(1, 2, 3, 6'h20);          // r3 = 2
        mem[3]  = enc_i(6'h2B, 0, 3, 32'h200);    // store r3
        mem[4]  = enc_i(6'h23, 0, 4, 32'h200);    // r4 = load
        mem[5]  = enc_i(6'h08, 4, 5, 32'h7FFF);   // r5 = 0x8001
        mem[6]  = enc_i(6'h2B, 0, 5, 32'h204);
        mem[7]  = enc_i(6'h04, 1, 2, 2);          // not taken
        mem[8]  = enc_i(6'h08, 0, 6, 1);          // r6 = 1
        mem[9]  = enc_i(6'h04, 3, 4, 1);          // taken, skips 10
        mem[10] = enc_i(6'h08, 6, 6, 100);
        mem[11] = enc_i(6'h08, 0, 0, 77);         // r0 write attempt
        mem[12] = enc_i(6'h2B, 0, 0, 32'h208);
        mem[13] = enc_i(6'h2B, 0, 6, 32'h20C);
        mem[14] = enc_r(2, 2, 7, 6'h20);          // r7 = -6
        mem[15] = enc_i(6'h2B, 0, 7, 32'h210);
        mem[16] = 32'hFC22_0000;                  // unknown opcode
        mem[17] = enc_i(6'h2B, 0, 1, 32'h214);
        p = 18;
        for (int k = 1; k < 32; k++) begin
            mem[p] = enc_i(6'h08, 0, k, sweep_val(k));
            p = p + 1;
        end
        for (int k = 1; k < 32; k++) begin
            mem[p] = enc_i(6'h2B, 0, k, 32'h300 + 4 * k);
            p = p + 1;
        end
        mem[HALT_IDX] = enc_i(6'h04, 0, 0, -1);

        repeat (3) @(negedge clk);
        chk(mem_we == 1'b0, "R1 we in reset", {31'd0, mem_we}, 32'd0);
        chk(mem_addr == 32'd0, "R1 addr in reset", mem_addr, 32'd0);
        rst = 1'b0;
        chk(mem_addr == 32'd0, "R2 first fetch addr", mem_addr, 32'd0);
        wait_cyc(3);
        chk(mem_addr == 32'd0, "R8 pc held until MEM", mem_addr, 32'd0);
        wait_cyc(5);
        chk(mem_addr == 32'd4, "R8 second fetch addr", mem_addr, 32'd4);

        guard = 0;
        while (!(mem_addr == 32'(HALT_IDX * 4) && cyc > 20) && guard < 20000) begin
            @(negedge clk);
            guard = guard + 1;
        end
        chk(guard < 20000, "watchdog halt reached", 32'(guard), 32'd20000);
        repeat (10) @(negedge clk);

        chk(wcyc0 == 18, "R8 first store cycle", 32'(wcyc0), 32'd18);
        chk(wcyc1 == 32, "R8 second store cycle", 32'(wcyc1), 32'd32);
        chk(mem[128] == 32'd2, "R3 add result", mem[128], 32'd2);
        chk(mem[129] == 32'h0000_8001, "R5 R4 load then addi", mem[129], 32'h0000_8001);
        chk(mem[130] == 32'd0, "R7 r0 stays zero", mem[130], 32'd0);
        chk(mem[131] == 32'd1, "R6 branch taken and not taken", mem[131], 32'd1);
        chk(mem[132] == 32'hFFFF_FFFA, "R3 negative sum", mem[132], 32'hFFFF_FFFA);
        chk(mem[133] == 32'd5, "R9 nop preserves r1", mem[133], 32'd5);
        chk(nwr == 37, "R9 store count", 32'(nwr), 32'd37);
        for (int k = 1; k < 32; k++) begin
            chk(mem[192 + k] == 32'(sweep_val(k)), "R10 R4 register sweep",
                mem[192 + k], 32'(sweep_val(k)));
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule